// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a Clause 22 MDIO management master that software controls through four 32-bit registers on a plain address / write-enable / data port. Software first sets an MDC divider and, for writes, a 16-bit payload. It then writes the frame-control word with its launch bit set. The block serialises one complete management frame on MDC and MDIO. For a read frame it releases MDIO from the turnaround onward and shifts in the PHY's reply. The reply and a read-OK flag then appear in the status register.

The frame-control word's launch bit reads back as 1 while a frame is running and drops to 0 by itself when the frame ends, so software polls that bit to see when the block is done. The read-OK flag holds the inverse of the level seen on MDIO in the second turnaround bit of a read. A PHY that drives 1 in that bit therefore marks the read as failed.

The sequencer has three named states. IDLE waits for a launch. MDC_LO holds MDC low with the current bit on MDIO. MDC_HI holds MDC high. Transitions: IDLE→MDC_LO on an accepted launch. MDC_LO→MDC_HI when a half-period expires, and a read samples MDIO at this point. MDC_HI→MDC_LO when a half-period expires and bits remain, with the next bit presented. MDC_HI→IDLE when the half-period of the last bit expires.

Top module: `mdio_host`

## Requirements
- R1: After reset the divider reads 4 and the payload, frame-control and status registers read 0. MDC is low, MDIO output-enable is low and the MDIO output level is high.
- R2: Registers are addressed by byte offset. 0x20 holds the divider in bits 7:0. 0x24 holds the write payload in bits 15:0. 0x28 is frame control: bit 31 launch/busy, bits 20:16 register address, bits 8:4 PHY address, bits 3:2 opcode, bits 1:0 start code. 0x2C is status: bit 24 read-OK, bits 15:0 read data. Unlisted bits read 0.
- R3: Each MDC half-period lasts div+1 clock cycles. A frame keeps the busy bit set for exactly 128·(div+1) cycles.
- R4: A write of 0 to the divider is ignored and the previous value is kept.
- R5: A write to 0x28 with bit 31 set, while idle, launches a frame. Bit 31 reads 1 from the cycle after that write until the frame ends, then reads 0.
- R6: While a frame is running, writes to any register are ignored. They start no new frame and change no stored field.
- R7: Every frame is 64 MDC cycles long. It opens with 32 bits of 1, followed by the start code, the opcode, the PHY address and the register address, each sent most significant bit first. MDIO changes only while MDC is low (on the falling edge) and stays stable while MDC is high.
- R8: For any opcode other than 10, the master drives the turnaround as 1 then 0, then the 16 payload bits MSB first. Output-enable stays high for all 64 bits.
- R9: For opcode 10 (read), output-enable is low for the two turnaround bits and the 16 data bits. The 16 data bits are sampled at MDC rising edges, MSB first, and placed in status bits 15:0 when the frame ends.
- R10: Status bit 24 equals the inverse of the MDIO level sampled in the second turnaround bit of a read. Write frames leave the status register unchanged.
- R11: Between frames MDC is low, output-enable is low and the MDIO output level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output level |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO level from the pad |

## Verification
Some properties can be checked on every cycle by the assertions. MDIO must be stable while MDC is high. The idle pin levels must hold. A read must keep output-enable low past the first turnaround bit, and a write must keep it high throughout. Stored fields must not change while busy, and a new frame must start at bit 0 with MDC low. The bench scenarios cover what needs an external reference. They rebuild each captured frame bit by bit. They measure the exact busy length and the MDC high time. They check the read data and the read-OK value returned by a modelled PHY, including a failed read, and confirm that writes made mid-frame leave no trace.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MDC_LO,
        ST_MDC_HI
    } seq_state_t;

    localparam logic [5:0] OFS_DIV   = 6'h20;
    localparam logic [5:0] OFS_WDATA = 6'h24;
    localparam logic [5:0] OFS_CTRL  = 6'h28;
    localparam logic [5:0] OFS_STAT  = 6'h2C;

    localparam int LAUNCH_BIT = 31;
    localparam int OK_BIT     = 24;
    localparam int MII_DATA_W = 16;

    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic [4:0] regad;
        logic [4:0] phy;
        logic [1:0] op;
        logic [1:0] sof;
    } frame_cfg_t;

endpackage

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_host_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [5:0]            reg_addr,
    input  logic                  reg_we,
    input  logic [31:0]           reg_wdata,
    input  logic                  busy,
    input  logic                  cap_valid,
    input  logic [MII_DATA_W-1:0] cap_data,
    input  logic                  cap_ok,
    output logic [DIV_W-1:0]      div_q,
    output logic [MII_DATA_W-1:0] wdata_q,
    output frame_cfg_t            cfg_q,
    output frame_cfg_t            launch_cfg,
    output logic                  start,
    output logic [31:0]           reg_rdata
);

    logic                  wr_ok;
    logic [MII_DATA_W-1:0] stat_data;
    logic                  stat_ok;
    logic                  unused_wbits;

    assign unused_wbits = ^{reg_wdata[30:21], reg_wdata[15:9]};

    always_comb begin
        launch_cfg.regad = reg_wdata[20:16];
        launch_cfg.phy   = reg_wdata[8:4];
        launch_cfg.op    = reg_wdata[3:2];
        launch_cfg.sof   = reg_wdata[1:0];
        wr_ok = reg_we && !busy;
        start = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[LAUNCH_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= DIV_RST;
            wdata_q   <= '0;
            cfg_q     <= '0;
            stat_data <= '0;
            stat_ok   <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    OFS_DIV: begin
                        if (reg_wdata[DIV_W-1:0] != '0)
                            div_q <= reg_wdata[DIV_W-1:0];
                    end
                    OFS_WDATA: wdata_q <= reg_wdata[MII_DATA_W-1:0];
                    OFS_CTRL:  cfg_q   <= launch_cfg;
                    default: ;
                endcase
            end
            if (cap_valid) begin
                stat_data <= cap_data;
                stat_ok   <= cap_ok;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DIV:   reg_rdata[DIV_W-1:0] = div_q;
            OFS_WDATA: reg_rdata[MII_DATA_W-1:0] = wdata_q;
            OFS_CTRL: begin
                reg_rdata[LAUNCH_BIT] = busy;
                reg_rdata[20:16]      = cfg_q.regad;
                reg_rdata[8:4]        = cfg_q.phy;
                reg_rdata[3:2]        = cfg_q.op;
                reg_rdata[1:0]        = cfg_q.sof;
            end
            OFS_STAT: begin
                reg_rdata[OK_BIT]           = stat_ok;
                reg_rdata[MII_DATA_W-1:0]   = stat_data;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_host_tick.sv
module mdio_host_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_done
);

    logic [DIV_W-1:0] cnt;

    assign half_done = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || half_done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/mdio_host_seq.sv
module mdio_host_seq
    import mdio_host_pkg::*;
#(
    parameter int PRE_LEN    = 32,
    localparam int FRAME_BITS = PRE_LEN + 32,
    localparam int IDX_W      = $clog2(FRAME_BITS),
    localparam int TA_FIRST   = PRE_LEN + 14,
    localparam int TA_SECOND  = PRE_LEN + 15,
    localparam int DATA_FIRST = PRE_LEN + 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  frame_cfg_t            launch_cfg,
    input  logic [MII_DATA_W-1:0] wdata,
    input  logic                  half_done,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  mdc,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [IDX_W-1:0]      bit_idx,
    output logic                  cap_valid,
    output logic [MII_DATA_W-1:0] cap_data,
    output logic                  cap_ok
);

    seq_state_t            state_q, state_d;
    logic [FRAME_BITS-1:0] frm;
    logic                  rd_mode;
    logic                  last_bit;
    logic                  launch_rd;
    logic [MII_DATA_W-1:0] cap_sh;
    logic                  ok_q;

    assign last_bit  = (bit_idx == IDX_W'(FRAME_BITS - 1));
    assign launch_rd = (launch_cfg.op == OP_READ);
    assign busy      = (state_q != ST_IDLE);
    assign mdio_o    = frm[FRAME_BITS-1];
    assign cap_valid = (state_q == ST_MDC_HI) && half_done && last_bit && rd_mode;
    assign cap_data  = cap_sh;
    assign cap_ok    = ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_MDC_LO;
            ST_MDC_LO: if (half_done) state_d = ST_MDC_HI;
            ST_MDC_HI: if (half_done) state_d = last_bit ? ST_IDLE : ST_MDC_LO;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm     <= '1;
            bit_idx <= '0;
            mdc     <= 1'b0;
            mdio_oe <= 1'b0;
            rd_mode <= 1'b0;
            cap_sh  <= '0;
            ok_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        frm <= {{PRE_LEN{1'b1}}, launch_cfg.sof, launch_cfg.op,
                                launch_cfg.phy, launch_cfg.regad,
                                launch_rd ? 2'b11 : 2'b10,
                                launch_rd ? {MII_DATA_W{1'b1}} : wdata};
                        bit_idx <= '0;
                        mdc     <= 1'b0;
                        mdio_oe <= 1'b1;
                        rd_mode <= launch_rd;
                    end
                end
                ST_MDC_LO: begin
                    if (half_done) begin
                        mdc <= 1'b1;
                        if (rd_mode) begin
                            if (bit_idx == IDX_W'(TA_SECOND))
                                ok_q <= ~mdio_i;
                            if (bit_idx >= IDX_W'(DATA_FIRST))
                                cap_sh <= {cap_sh[MII_DATA_W-2:0], mdio_i};
                        end
                    end
                end
                ST_MDC_HI: begin
                    if (half_done) begin
                        mdc <= 1'b0;
                        frm <= {frm[FRAME_BITS-2:0], 1'b1};
                        if (last_bit) begin
                            bit_idx <= '0;
                            mdio_oe <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            if (rd_mode && bit_idx >= IDX_W'(TA_FIRST - 1))
                                mdio_oe <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mdio_host.sv
module mdio_host
    import mdio_host_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = 4,
    parameter int               PRE_LEN = 32,
    localparam int              IDX_W   = $clog2(PRE_LEN + 32)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [DIV_W-1:0]      div_q;
    logic [MII_DATA_W-1:0] wdata_q;
    frame_cfg_t            cfg_q;
    frame_cfg_t            launch_cfg;
    logic                  start;
    logic                  busy;
    logic                  half_done;
    logic [IDX_W-1:0]      bit_idx;
    logic                  cap_valid;
    logic [MII_DATA_W-1:0] cap_data;
    logic                  cap_ok;

    mdio_host_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .busy(busy), .cap_valid(cap_valid), .cap_data(cap_data), .cap_ok(cap_ok),
        .div_q(div_q), .wdata_q(wdata_q), .cfg_q(cfg_q), .launch_cfg(launch_cfg),
        .start(start), .reg_rdata(reg_rdata)
    );

    mdio_host_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .half_done(half_done)
    );

    mdio_host_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .launch_cfg(launch_cfg),
        .wdata(wdata_q), .half_done(half_done), .mdio_i(mdio_i),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .bit_idx(bit_idx), .cap_valid(cap_valid), .cap_data(cap_data), .cap_ok(cap_ok)
    );

endmodule

// File: rtl/mdio_host_chk.sv
module mdio_host_chk
    import mdio_host_pkg::*;
#(
    parameter int  DIV_W    = 8,
    parameter int  PRE_LEN  = 32,
    localparam int IDX_W    = $clog2(PRE_LEN + 32),
    localparam int TA_FIRST = PRE_LEN + 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [IDX_W-1:0] bit_idx,
    input frame_cfg_t       cfg_q,
    input logic [DIV_W-1:0] div_q
);

    a_r7_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r11_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe && mdio_o));

    a_r9_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.op == OP_READ && bit_idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe);

    a_r8_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.op != OP_READ) |-> mdio_oe);

    a_r6_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ($stable(cfg_q) && $stable(div_q)));

    a_r5_launch_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bit_idx == '0 && !mdc && mdio_oe));

    a_r4_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        div_q != '0);

endmodule

bind mdio_host mdio_host_chk #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .bit_idx(bit_idx), .cfg_q(cfg_q), .div_q(div_q)
);

// File: tb/sim_mdio_host.sv
`timescale 1ns/1ps
module sim_mdio_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int total = 0;
    int bad = 0;

    logic [63:0] resp = '1;
    int          falls = 0;
    int          rises = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    logic [63:0] exp_o, exp_oe;
    logic [31:0] exp_stat = '0;

    always #2.5 clk = ~clk;

    mdio_host u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    assign mdio_i = (falls < 64) ? resp[63 - falls] : 1'b1;

    always @(negedge mdc) falls = falls + 1;

    always @(posedge mdc) begin
        if (rises < 64) begin
            cap_o[63 - rises]  = mdio_o;
            cap_oe[63 - rises] = mdio_oe;
        end
        rises = rises + 1;
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input bit launch, input bit is_rd,
                                              input logic [4:0] phy, input logic [4:0] ra);
        return {launch, 10'b0, ra, 7'b0, phy, is_rd ? 2'b10 : 2'b01, 2'b01};
    endfunction

    task automatic launch(input bit is_rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] d, input logic ta2);
        resp = {32'hFFFF_FFFF, 14'h3FFF, 1'b1, ta2, d};
        exp_oe = is_rd ? {{46{1'b1}}, 18'b0} : '1;
        exp_o  = {32'hFFFF_FFFF, 2'b01, is_rd ? 2'b10 : 2'b01, phy, ra,
                  is_rd ? 2'b00 : 2'b10, is_rd ? 16'h0 : d};
        if (!is_rd) wr(6'h24, {16'h0, d});
        falls = 0; rises = 0; cap_o = '0; cap_oe = '0;
        wr(6'h28, ctrl_word(1'b1, is_rd, phy, ra));
        reg_addr = 6'h28;
        #1;
        chk(reg_rdata[31] == 1'b1, "R5 busy after launch", 64'(reg_rdata[31]), 64'd1);
    endtask

    task automatic wait_done(output int n, output int hmin, output int hmax);
        int hrun;
        n = 1; hrun = 0; hmin = 100000; hmax = 0;
        reg_addr = 6'h28;
        forever begin
            @(negedge clk);
            if (mdc) hrun++;
            else if (hrun > 0) begin
                if (hrun < hmin) hmin = hrun;
                if (hrun > hmax) hmax = hrun;
                hrun = 0;
            end
            if (!reg_rdata[31]) break;
            n++;
        end
    endtask

    task automatic check_frame(input string tag);
        chk(rises == 64, "R7 mdc cycles", 64'(rises), 64'd64);
        chk(cap_o[63:18] == exp_o[63:18], "R7 header bits", cap_o, exp_o);
        chk(cap_oe == exp_oe, {tag, " output enable"}, cap_oe, exp_oe);
        chk((cap_o & exp_oe) == (exp_o & exp_oe), {tag, " driven bits"}, cap_o, exp_o);
    endtask

    localparam int NV = 6;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0},
        {1'b1, 5'h1F, 5'h1F, 16'h8001, 1'b0},
        {1'b1, 5'h00, 5'h10, 16'h7E5A, 1'b1},
        {1'b0, 5'h15, 5'h0A, 16'hFFFF, 1'b0},
        {1'b1, 5'h0A, 5'h15, 16'h0000, 1'b0},
        {1'b0, 5'h1E, 5'h01, 16'h0000, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, hmin, hmax;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h20, v); chk(v == 32'd4, "R1 divider reset", 64'(v), 64'd4);
        rd(6'h24, v); chk(v == 32'd0, "R1 payload reset", 64'(v), 64'd0);
        rd(6'h28, v); chk(v == 32'd0, "R1 control reset", 64'(v), 64'd0);
        rd(6'h2C, v); chk(v == 32'd0, "R1 status reset", 64'(v), 64'd0);
        chk({mdc, mdio_oe, mdio_o} == 3'b001, "R1 R11 idle pins", 64'({mdc, mdio_oe, mdio_o}), 64'd1);

        // R4 zero divider ignored; R2 divider field
        wr(6'h20, 32'h0); rd(6'h20, v);
        chk(v == 32'd4, "R4 zero divider ignored", 64'(v), 64'd4);
        wr(6'h20, 32'hFFFF_FF01); rd(6'h20, v);
        chk(v == 32'd1, "R2 divider field", 64'(v), 64'd1);

        // Vector table, divider 1
        for (int i = 0; i < NV; i++) begin
            logic        is_rd, ta2;
            logic [4:0]  phy, ra;
            logic [15:0] d;
            {is_rd, phy, ra, d, ta2} = VEC[i];
            launch(is_rd, phy, ra, d, ta2);
            wait_done(n, hmin, hmax);
            chk(n == 256, "R3 R5 busy length div1", 64'(n), 64'd256);
            check_frame(is_rd ? "R9" : "R8");
            if (is_rd) exp_stat = {7'b0, ~ta2, 8'b0, d};
            rd(6'h2C, v);
            chk(v == exp_stat, "R9 R10 status", 64'(v), 64'(exp_stat));
            rd(6'h28, v);
            chk(v == ctrl_word(1'b0, is_rd, phy, ra), "R2 R5 control readback", 64'(v),
                64'(ctrl_word(1'b0, is_rd, phy, ra)));
            chk({mdc, mdio_oe, mdio_o} == 3'b001, "R11 idle after frame",
                64'({mdc, mdio_oe, mdio_o}), 64'd1);
        end

        // R3 longer divider: period and length
        wr(6'h20, 32'd3);
        launch(1'b0, 5'h05, 5'h06, 16'h3C96, 1'b0);
        wait_done(n, hmin, hmax);
        chk(n == 512, "R3 busy length div3", 64'(n), 64'd512);
        chk(hmin == 4 && hmax == 4, "R3 mdc high time", 64'({hmin[15:0], hmax[15:0]}), 64'h0004_0004);
        check_frame("R8");

        // R6 writes ignored mid-frame
        launch(1'b1, 5'h11, 5'h02, 16'hBEEF, 1'b0);
        repeat (40) @(negedge clk);
        wr(6'h28, ctrl_word(1'b1, 1'b0, 5'h07, 5'h09));
        wr(6'h24, 32'h0000_1234);
        wr(6'h20, 32'd7);
        wait_done(n, hmin, hmax);
        check_frame("R6 R9");
        rd(6'h28, v);
        chk(v == ctrl_word(1'b0, 1'b1, 5'h11, 5'h02), "R6 control unchanged", 64'(v),
            64'(ctrl_word(1'b0, 1'b1, 5'h11, 5'h02)));
        rd(6'h24, v); chk(v == 32'h3C96, "R6 payload unchanged", 64'(v), 64'h3C96);
        rd(6'h20, v); chk(v == 32'd3, "R6 divider unchanged", 64'(v), 64'd3);
        rd(6'h2C, v); chk(v == 32'h0100_BEEF, "R9 R10 status after read", 64'(v), 64'h0100_BEEF);
        rises = 0;
        repeat (30) @(negedge clk);
        chk(rises == 0 && !mdc, "R6 no second frame", 64'(rises), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule